// File: doc/BRIEF.md
# Queue Interrupt Control Register File

This block is the host-visible register file of a two-port host adapter with four request queues and four response queues. A host reads and writes four 32-bit word registers over a simple byte-addressed bus: a configuration word for the bus engine, a log of faulty slave accesses, a command/status word that summarises queue state, and an interrupt enable mask. The block collects per-queue status pulses from the queue engines. It raises a single level interrupt from the enabled conditions and issues a one-cycle soft reset to the engines.

Response-queue bits go to 1 when the engine posts a response, and the host acknowledges them by writing 1. Request-queue bits work the other way round. The host sets a bit to post work, and the engine clears it when that queue has drained. A cleared request bit is therefore an interrupt source. Access errors are sticky and stay set until the host writes 1 to them. Read data is combinational, and register updates take effect on the clock edge that follows the write.

Top module: `hba_irq_regfile`

## Requirements
- R1: After reset every register reads 0 (command/status bit 1 follows `engine_idle`), and `irq` and `soft_reset` are low.
- R2: Registers are decoded by byte offset: configuration at 0x00, access error at 0x04, command/status at 0x08, interrupt mask at 0x0C. Only configuration bits 5:0 are writable. Only mask bits 19:16, 11:8, 7 and 2 are writable. All other bits read 0, and reads outside the map return 0.
- R3: Configuration bits 2:0 select the burst length and are brought out as `cfg_burst_bytes`: code 0 gives 4, 4 gives 16, 5 gives 32 and 6 gives 64. Any other code falls back to 4. Bits 3, 4 and 5 drive `cfg_enhanced`, `cfg_parity_check` and `cfg_parity_test`.
- R4: Command/status bits 19:16 hold response queues 0..3. A `rsp_post` pulse sets its bit, and writing 1 clears it. When a post and a clear of the same bit fall in one cycle, the bit stays set.
- R5: Command/status bits 11:8 hold request queues 0..3. Writing 1 sets a bit, writing 0 leaves it alone, and a `req_done` pulse clears it. When a host set and a done pulse fall in one cycle, the bit ends set.
- R6: Command/status bit 2 is set by `nq_event` and cleared by writing 1. The event wins over a clear in the same cycle.
- R7: Access-error bit 2 is set by any access whose offset is not word aligned, and such an access changes no register. Bit 1 is set by an aligned access outside the map. Bit 0 is set by `parity_err` only while parity checking (configuration bit 4) is on. The bits are cleared by writing 1, and a new error wins over a clear in the same cycle. Command/status bit 7 reads the OR of the three.
- R8: `irq` is the OR over all bits of (response bits at 19:16, inverted request bits at 11:8, the error summary at bit 7, the non-queued bit at bit 2) ANDed with the mask. It follows register state in the same cycle. Command/status bit 3 reads `irq`, and writes to that bit are ignored.
- R9: Writing 1 to command/status bit 0 makes `soft_reset` and bit 0 read 1 for exactly the next cycle. At the edge ending that cycle, the queue, non-queued and error bits clear, and this clear wins over any event. Configuration and mask are kept.
- R10: Command/status bit 1 reads the `engine_idle` input and cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (8) | Byte address of the access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| rsp_post | input | NQ (4) | One pulse per response posted, per queue |
| req_done | input | NQ (4) | One pulse per drained request queue |
| nq_event | input | 1 | Non-queued event pulse |
| engine_idle | input | 1 | Engine idle level |
| parity_err | input | 1 | Bus parity error pulse |
| irq | output | 1 | Interrupt request, level |
| soft_reset | output | 1 | One-cycle soft reset to the engines |
| cfg_burst_bytes | output | 7 | Decoded burst length in bytes |
| cfg_enhanced | output | 1 | Enhanced bus mode enable |
| cfg_parity_check | output | 1 | Parity check enable |
| cfg_parity_test | output | 1 | Parity test mode |

## Verification
A host write that clears or sets a status bit can land in the same cycle as an engine pulse that touches that same bit. The same applies to error inputs arriving during the soft reset cycle. The bench provokes these collisions with directed cases, such as a response post paired with its acknowledge write and a misaligned access issued while the soft reset is active. It also produces them by chance in long random runs. Each outcome is judged against a bench model that applies the stated priorities: event over clear, host set over done, and soft reset over everything.

// File: rtl/hba_irq_pkg.sv
package hba_irq_pkg;
  localparam int REG_W    = 32;
  localparam int QN       = 4;
  // word indices of the registers (byte offset / 4)
  localparam int WI_CFG   = 0;
  localparam int WI_ERR   = 1;
  localparam int WI_CMD   = 2;
  localparam int WI_MASK  = 3;
  localparam int NREGS    = 4;
  // command/status and mask bit positions
  localparam int RSP_LSB  = 16;
  localparam int REQ_LSB  = 8;
  localparam int BIT_ERR  = 7;
  localparam int BIT_PEND = 3;
  localparam int BIT_NQ   = 2;
  localparam int BIT_IDLE = 1;
  localparam int BIT_SRST = 0;
  // configuration fields
  localparam int CFG_W     = 6;
  localparam int CFG_ENH   = 3;
  localparam int CFG_PCHK  = 4;
  localparam int CFG_PTEST = 5;
  localparam logic [REG_W-1:0] MASK_WMASK = 32'h000F_0F84;

  typedef struct packed {
    logic misalign;
    logic unsupp;
    logic parity;
  } err_t;

  function automatic logic [6:0] burst_bytes(input logic [2:0] code);
    case (code)
      3'd4:    return 7'd16;
      3'd5:    return 7'd32;
      3'd6:    return 7'd64;
      default: return 7'd4;
    endcase
  endfunction
endpackage

// File: rtl/hba_bus_decode.sv
module hba_bus_decode
  import hba_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              acc,
  output logic              misalign,
  output logic              unmapped,
  output logic [NREGS-1:0]  sel
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              mapped;

  assign acc      = wr | rd;
  assign word     = addr[ADDR_W-1:2];
  assign mapped   = (word < WORD_W'(NREGS));
  assign misalign = acc && (addr[1:0] != 2'b00);
  assign unmapped = acc && !misalign && !mapped;

  for (genvar k = 0; k < NREGS; k++) begin : g_sel
    assign sel[k] = acc && !misalign && (word == WORD_W'(k));
  end
endmodule

// File: rtl/hba_err_log.sv
module hba_err_log
  import hba_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       misalign,
  input  logic       unmapped,
  input  logic       parity_in,
  input  logic       pchk_en,
  input  logic       clr_we,
  input  logic [2:0] clr_bits,
  output err_t       err_q,
  output logic       err_any
);
  err_t err_set;
  err_t err_clr;

  assign err_set = '{misalign: misalign, unsupp: unmapped, parity: parity_in & pchk_en};
  assign err_clr = clr_we ? err_t'(clr_bits) : err_t'(3'b000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    err_q <= '0;
    else if (srst) err_q <= '0;
    else           err_q <= (err_q & ~err_clr) | err_set;
  end

  assign err_any = |err_q;

  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && (err_set != 3'b000)) |=> ((err_q & $past(err_set)) == $past(err_set))); // R7
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && (err_clr == 3'b000)) |=> ((err_q & $past(err_q)) == $past(err_q))); // R7
  AST_PAR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && !pchk_en && err_clr.parity) |=> !err_q.parity); // R7
endmodule

// File: rtl/hba_queue_status.sv
module hba_queue_status
  import hba_irq_pkg::*;
#(
  parameter int NQ = QN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [NQ-1:0] wr_rsp_bits,
  input  logic [NQ-1:0] wr_req_bits,
  input  logic          wr_nq_bit,
  input  logic          wr_srst_bit,
  input  logic [NQ-1:0] rsp_post,
  input  logic [NQ-1:0] req_done,
  input  logic          nq_evt,
  output logic [NQ-1:0] rsp_q,
  output logic [NQ-1:0] req_q,
  output logic          nq_q,
  output logic          srst_q
);
  logic [NQ-1:0] rsp_ack;
  logic [NQ-1:0] req_set;
  logic          nq_ack;
  logic          srst_req;

  assign rsp_ack  = cmd_we ? wr_rsp_bits : '0;
  assign req_set  = cmd_we ? wr_req_bits : '0;
  assign nq_ack   = cmd_we & wr_nq_bit;
  assign srst_req = cmd_we & wr_srst_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q  <= '0;
      req_q  <= '0;
      nq_q   <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      srst_q <= srst_req;
      if (srst_q) begin
        rsp_q <= '0;
        req_q <= '0;
        nq_q  <= 1'b0;
      end else begin
        rsp_q <= (rsp_q & ~rsp_ack) | rsp_post;
        req_q <= (req_q & ~req_done) | req_set;
        nq_q  <= (nq_q & ~nq_ack) | nq_evt;
      end
    end
  end

  AST_RSP_POST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_q && (rsp_post != '0)) |=> ((rsp_q & $past(rsp_post)) == $past(rsp_post))); // R4
  AST_REQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_q && (req_set != '0)) |=> ((req_q & $past(req_set)) == $past(req_set))); // R5
  AST_NQ_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_q && nq_evt) |=> nq_q); // R6
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (rsp_q == '0 && req_q == '0 && !nq_q)); // R9
  AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_q && !srst_req) |=> !srst_q); // R9
endmodule

// File: rtl/hba_irq_gen.sv
module hba_irq_gen
  import hba_irq_pkg::*;
#(
  parameter int NQ = QN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NQ-1:0]    rsp_q,
  input  logic [NQ-1:0]    req_q,
  input  logic             err_any,
  input  logic             nq_q,
  input  logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] cond,
  output logic             irq
);
  logic [REG_W-1:0] pend_vec;

  for (genvar b = 0; b < REG_W; b++) begin : g_cond
    if (b >= RSP_LSB && b < RSP_LSB + NQ) begin : g_rsp
      assign cond[b] = rsp_q[b-RSP_LSB];
    end else if (b >= REQ_LSB && b < REQ_LSB + NQ) begin : g_req
      assign cond[b] = ~req_q[b-REQ_LSB];
    end else if (b == BIT_ERR) begin : g_err
      assign cond[b] = err_any;
    end else if (b == BIT_NQ) begin : g_nq
      assign cond[b] = nq_q;
    end else begin : g_zero
      assign cond[b] = 1'b0;
    end
  end

  assign pend_vec = cond & mask_q;
  assign irq      = |pend_vec;

  AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R8
  AST_IRQ_REQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q[REQ_LSB +: NQ] & ~req_q) != '0) |-> irq); // R8
  AST_IRQ_RSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q[RSP_LSB +: NQ] & rsp_q) != '0) |-> irq); // R8
endmodule

// File: rtl/hba_irq_regfile.sv
module hba_irq_regfile
  import hba_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NQ     = QN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NQ-1:0]     rsp_post,
  input  logic [NQ-1:0]     req_done,
  input  logic              nq_event,
  input  logic              engine_idle,
  input  logic              parity_err,
  output logic              irq,
  output logic              soft_reset,
  output logic [6:0]        cfg_burst_bytes,
  output logic              cfg_enhanced,
  output logic              cfg_parity_check,
  output logic              cfg_parity_test
);
  logic             acc;
  logic             misalign;
  logic             unmapped;
  logic [NREGS-1:0] sel;
  logic [NREGS-1:0] we;
  logic [CFG_W-1:0] cfg_q;
  logic [REG_W-1:0] mask_q;
  logic [NQ-1:0]    rsp_q;
  logic [NQ-1:0]    req_q;
  logic             nq_q;
  logic             srst_q;
  err_t             err_q;
  logic             err_any;
  logic [REG_W-1:0] cond;
  logic [REG_W-1:0] cmd_view;

  hba_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (reg_addr),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .acc      (acc),
    .misalign (misalign),
    .unmapped (unmapped),
    .sel      (sel)
  );

  assign we = sel & {NREGS{reg_wr}};

  hba_queue_status #(.NQ(NQ)) u_q (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (we[WI_CMD]),
    .wr_rsp_bits (reg_wdata[RSP_LSB +: NQ]),
    .wr_req_bits (reg_wdata[REQ_LSB +: NQ]),
    .wr_nq_bit   (reg_wdata[BIT_NQ]),
    .wr_srst_bit (reg_wdata[BIT_SRST]),
    .rsp_post    (rsp_post),
    .req_done    (req_done),
    .nq_evt      (nq_event),
    .rsp_q       (rsp_q),
    .req_q       (req_q),
    .nq_q        (nq_q),
    .srst_q      (srst_q)
  );

  hba_err_log u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst      (srst_q),
    .misalign  (misalign),
    .unmapped  (unmapped),
    .parity_in (parity_err),
    .pchk_en   (cfg_q[CFG_PCHK]),
    .clr_we    (we[WI_ERR]),
    .clr_bits  (reg_wdata[2:0]),
    .err_q     (err_q),
    .err_any   (err_any)
  );

  hba_irq_gen #(.NQ(NQ)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .rsp_q   (rsp_q),
    .req_q   (req_q),
    .err_any (err_any),
    .nq_q    (nq_q),
    .mask_q  (mask_q),
    .cond    (cond),
    .irq     (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '0;
    end else begin
      if (we[WI_CFG])  cfg_q  <= reg_wdata[CFG_W-1:0];
      if (we[WI_MASK]) mask_q <= reg_wdata & MASK_WMASK;
    end
  end

  always_comb begin
    cmd_view                   = '0;
    cmd_view[RSP_LSB +: NQ]    = rsp_q;
    cmd_view[REQ_LSB +: NQ]    = req_q;
    cmd_view[BIT_ERR]          = err_any;
    cmd_view[BIT_PEND]         = irq;
    cmd_view[BIT_NQ]           = nq_q;
    cmd_view[BIT_IDLE]         = engine_idle;
    cmd_view[BIT_SRST]         = srst_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (sel[WI_CFG])  reg_rdata = REG_W'(cfg_q);
      if (sel[WI_ERR])  reg_rdata = REG_W'(err_q);
      if (sel[WI_CMD])  reg_rdata = cmd_view;
      if (sel[WI_MASK]) reg_rdata = mask_q;
    end
  end

  assign soft_reset       = srst_q;
  assign cfg_burst_bytes  = burst_bytes(cfg_q[2:0]);
  assign cfg_enhanced     = cfg_q[CFG_ENH];
  assign cfg_parity_check = cfg_q[CFG_PCHK];
  assign cfg_parity_test  = cfg_q[CFG_PTEST];

  AST_BURST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot(cfg_burst_bytes) && cfg_burst_bytes >= 7'd4)); // R3
  AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && misalign) |=> ($stable(cfg_q) && $stable(mask_q))); // R7
  AST_MISALIGN_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && misalign && !srst_q) |=> err_q.misalign); // R7
  AST_PEND_MATCHES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel[WI_CMD]) |-> (reg_rdata[BIT_PEND] == irq)); // R8
endmodule

// File: tb/hba_irq_regfile_bench.sv
module hba_irq_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  rsp_post = '0;
  logic [3:0]  req_done = '0;
  logic        nq_event = 1'b0;
  logic        engine_idle = 1'b0;
  logic        parity_err = 1'b0;
  logic        irq;
  logic        soft_reset;
  logic [6:0]  cfg_burst_bytes;
  logic        cfg_enhanced;
  logic        cfg_parity_check;
  logic        cfg_parity_test;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // model state
  logic [5:0]  m_cfg;
  logic [31:0] m_mask;
  logic [3:0]  m_rsp, m_req;
  logic        m_nq, m_srst;
  logic [2:0]  m_err;

  always #10 clk = ~clk;  // 50 MHz

  hba_irq_regfile u_hba_irq_regfile (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rsp_post(rsp_post), .req_done(req_done),
    .nq_event(nq_event), .engine_idle(engine_idle), .parity_err(parity_err), .irq(irq),
    .soft_reset(soft_reset), .cfg_burst_bytes(cfg_burst_bytes), .cfg_enhanced(cfg_enhanced),
    .cfg_parity_check(cfg_parity_check), .cfg_parity_test(cfg_parity_test)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] exp_burst(input logic [2:0] c);
    if (c == 3'd6) return 7'd64;
    if (c == 3'd5) return 7'd32;
    if (c == 3'd4) return 7'd16;
    return 7'd4;
  endfunction

  function automatic logic exp_irq();
    logic [31:0] src;
    src = {12'd0, m_rsp, 4'd0, ~m_req, (|m_err), 4'd0, m_nq, 2'd0};
    return |(src & m_mask);
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a[1:0] != 2'b00 || a >= 8'h10) return 32'd0;
    case (a[3:2])
      2'd0:    return {26'd0, m_cfg};
      2'd1:    return {29'd0, m_err};
      2'd2:    return {12'd0, m_rsp, 4'd0, m_req, (|m_err), 3'd0, exp_irq(), m_nq, engine_idle, m_srst};
      default: return m_mask;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a[1:0] != 2'b00 || a >= 8'h10) return "R2 unmapped/misaligned read";
    case (a[3:2])
      2'd0:    return "R2 config read";
      2'd1:    return "R7 error read";
      2'd2:    return "R5 cmd/status read";
      default: return "R2 mask read";
    endcase
  endfunction

  // one bus cycle: drive, compare in mid-cycle, advance model at edge
  task automatic step(input bit wr, input bit rd, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] post, input logic [3:0] done, input bit nqe,
                      input bit par, input bit idle);
    bit mis, unm, wcmd, werr;
    logic [3:0] n_rsp, n_req;
    logic n_nq;
    logic [2:0] n_err;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    rsp_post = post; req_done = done; nq_event = nqe; parity_err = par; engine_idle = idle;
    #2;
    chk("R8 irq", {31'd0, irq}, {31'd0, exp_irq()});
    chk("R9 soft_reset", {31'd0, soft_reset}, {31'd0, m_srst});
    chk("R3 burst bytes", {25'd0, cfg_burst_bytes}, {25'd0, exp_burst(m_cfg[2:0])});
    if (rd) chk(tag_of(a), reg_rdata, exp_read(a));
    mis  = (wr || rd) && (a[1:0] != 2'b00);
    unm  = (wr || rd) && !mis && (a >= 8'h10);
    wcmd = wr && !mis && !unm && a[3:2] == 2'd2;
    werr = wr && !mis && !unm && a[3:2] == 2'd1;
    if (m_srst) begin
      n_rsp = 4'd0; n_req = 4'd0; n_nq = 1'b0; n_err = 3'd0;
    end else begin
      n_rsp = (m_rsp & ~(wcmd ? d[19:16] : 4'd0)) | post;
      n_req = (m_req & ~done) | (wcmd ? d[11:8] : 4'd0);
      n_nq  = (m_nq & ~(wcmd & d[2])) | nqe;
      n_err = (m_err & ~(werr ? d[2:0] : 3'd0)) | {mis, unm, par & m_cfg[4]};
    end
    @(posedge clk);
    #1;
    m_srst = wcmd && d[0];
    m_rsp = n_rsp; m_req = n_req; m_nq = n_nq; m_err = n_err;
    if (wr && !mis && !unm && a[3:2] == 2'd0) m_cfg = d[5:0];
    if (wr && !mis && !unm && a[3:2] == 2'd3) m_mask = d & 32'h000F_0F84;
    reg_wr = 1'b0; reg_rd = 1'b0; rsp_post = '0; req_done = '0; nq_event = 1'b0; parity_err = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, 1'b0, a, d, 4'd0, 4'd0, 1'b0, 1'b0, engine_idle);
  endtask
  task automatic rd(input logic [7:0] a);
    step(1'b0, 1'b1, a, 32'd0, 4'd0, 4'd0, 1'b0, 1'b0, engine_idle);
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    m_cfg = '0; m_mask = '0; m_rsp = '0; m_req = '0; m_nq = 1'b0; m_srst = 1'b0; m_err = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset values
    reg_rd = 1'b1;
    for (int i = 0; i < 4; i++) begin
      reg_addr = 8'(i * 4); #1;
      chk("R1 reset register value", reg_rdata, 32'd0);
    end
    reg_rd = 1'b0; #1;
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 soft_reset after reset", {31'd0, soft_reset}, 32'd0);
    @(posedge clk); #1;

    // R10: idle bit
    engine_idle = 1'b1; rd(8'h08);
    chk("R10 idle bit", {31'd0, reg_rdata[1]}, 32'd1);
    engine_idle = 1'b0;

    // R2/R3: config writable field and burst decoding
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00);
    chk("R3 parity test output", {31'd0, cfg_parity_test}, 32'd1);
    chk("R3 enhanced output", {31'd0, cfg_enhanced}, 32'd1);
    foreach (exp_burst_codes[k]) begin end
    for (int c = 0; c < 8; c++) begin
      wr(8'h00, 32'(c)); rd(8'h00);
    end
    wr(8'h00, 32'd5); #1;
    chk("R3 code 5 is 32 bytes", {25'd0, cfg_burst_bytes}, 32'd32);

    // R2: mask writable bits; empty request queues interrupt (R8)
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C);
    chk("R2 mask writable bits", reg_rdata, 32'h000F_0F84);
    rd(8'h08);
    chk("R8 pending bit with all requests clear", {31'd0, reg_rdata[3]}, 32'd1);

    // R5: post work on all request queues, irq drops
    wr(8'h08, 32'h0000_0F08); rd(8'h08);
    chk("R5 request bits set, pending write ignored", reg_rdata & 32'h0000_0F08, 32'h0000_0F00);
    chk("R8 irq low when all requests busy", {31'd0, irq}, 32'd0);
    step(1'b1, 1'b0, 8'h08, 32'h0000_0400, 4'd0, 4'b0100, 1'b0, 1'b0, 1'b0);  // set vs done
    step(1'b0, 1'b0, 8'h00, 32'd0, 4'd0, 4'b0001, 1'b0, 1'b0, 1'b0);
    rd(8'h08);
    chk("R5 set beats done, done clears q0", {20'd0, reg_rdata[11:8], 8'd0}, 32'h0000_0E00);

    // R4: response post vs acknowledge in same cycle
    step(1'b1, 1'b0, 8'h08, 32'h0002_0000, 4'b0010, 4'd0, 1'b0, 1'b0, 1'b0);
    rd(8'h08);
    chk("R4 post beats acknowledge", {12'd0, reg_rdata[19:16], 16'd0}, 32'h0002_0000);
    wr(8'h08, 32'h0002_0000); rd(8'h08);
    chk("R4 acknowledge clears", {12'd0, reg_rdata[19:16], 16'd0}, 32'd0);

    // R6: non-queued event
    step(1'b0, 1'b0, 8'h00, 32'd0, 4'd0, 4'd0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 8'h08, 32'h0000_0004, 4'd0, 4'd0, 1'b1, 1'b0, 1'b0);
    rd(8'h08);
    chk("R6 event beats clear", {31'd0, reg_rdata[2]}, 32'd1);
    wr(8'h08, 32'h0000_0004);

    // R7: access errors
    wr(8'h01, 32'hFFFF_FFFF); rd(8'h00);
    chk("R7 misaligned write ignored", reg_rdata, {26'd0, m_cfg});
    rd(8'h20);
    wr(8'h00, 32'd0);
    step(1'b0, 1'b0, 8'h00, 32'd0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0);  // parity, check off
    rd(8'h04);
    chk("R7 misalign+unmapped, parity gated", reg_rdata, 32'h0000_0006);
    wr(8'h00, 32'h10);
    step(1'b1, 1'b0, 8'h04, 32'h0000_0007, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0);  // parity vs clear
    rd(8'h04);
    chk("R7 parity beats clear", reg_rdata, 32'h0000_0001);
    rd(8'h08);
    chk("R7 error summary bit", {31'd0, reg_rdata[7]}, 32'd1);

    // R9: soft reset, with a misaligned access during the reset cycle
    step(1'b1, 1'b0, 8'h08, 32'h0001_0F01, 4'b1000, 4'd0, 1'b1, 1'b0, 1'b0);
    chk("R9 soft reset high", {31'd0, soft_reset}, 32'd1);
    step(1'b0, 1'b1, 8'h03, 32'd0, 4'b0001, 4'd0, 1'b1, 1'b1, 1'b0);
    chk("R9 soft reset one cycle", {31'd0, soft_reset}, 32'd0);
    rd(8'h08);
    chk("R9 status cleared", reg_rdata & 32'h000F_0F85, 32'd0);
    rd(8'h04);
    chk("R9 errors cleared", reg_rdata, 32'd0);
    rd(8'h0C);
    chk("R9 mask kept", reg_rdata, 32'h000F_0F84);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      logic [7:0] a;
      logic [31:0] d;
      bit w, rr;
      r  = $urandom;
      w  = (r % 3) == 0;
      rr = !w && ((r % 3) == 1);
      a  = ($urandom % 16 == 0) ? 8'($urandom % 32) : 8'(($urandom % 4) * 4);
      d  = $urandom;
      if (a == 8'h08) d[0] = ($urandom % 32) == 0;
      step(w, rr, a, d, 4'($urandom % 16 == 0 ? $urandom : 0),
           4'($urandom % 8 == 0 ? $urandom : 0), ($urandom % 16) == 0,
           ($urandom % 20) == 0, 1'($urandom));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [2:0] exp_burst_codes [1];
endmodule